// File: doc/BRIEF.md
# Transceiver Serial Command Port with Interrupt Gathering

This block is the control front end of a radio transceiver. A host drives a four-wire serial link (select, clock, data in, data out) and sends 16-bit command words, most significant bit first. The leading bits of each word are a command code of variable length. The block matches the code against fifteen configuration registers and overwrites the matching register with the whole word. Each register leaves reset holding a fixed default word. The radio logic that uses these registers reads them from one flat output vector.

The block also collects five event sources into pending flags: FIFO fill level reached, FIFO overflow, transmit register ready, a falling edge on an external interrupt pin, and low supply. It drives an active-low interrupt line while any flag other than overflow is pending. A command word whose first bit is 0 is a status read. The block shifts out a 16-bit status word on the data-out line, and a completed status read clears the flags that the word reported. The serial pins are oversampled in the system clock domain, so the serial clock must be much slower than `clk`.

Top module: `xcvr_cmd_port`

## Requirements
- R1: After reset, `irq_n_o` is 1, `spi_sdo_o` is 0, and slot k of `cfg_words_o` (bits 16k+15..16k) holds its default: 0:8008h, 1:8208h, 2:9080h, 3:9800h, 4:A680h, 5:B8AAh, 6:C000h, 7:C22Ch, 8:C4F7h, 9:C623h, 10:C80Eh, 11:CA80h, 12:CC77h, 13:CED4h, 14:E196h.
- R2: While `spi_csn_i` is low, `spi_sdi_i` is sampled on each rising edge of `spi_sck_i`, first bit as bit 15. When select rises after exactly 16 bits, the register whose code matches is replaced by the entire word. Registers do not change while select stays low.
- R3: Matching uses bits 15..8 against the slot defaults' high byte, with two exceptions: slot 4 matches on bits 15..12 = 1010b and slot 14 on bits 15..13 = 111b. A word that matches no slot (for example D512h, 8455h or B0xxh) changes no register.
- R4: A frame with fewer or more than 16 bits changes no register, and a status read of that kind clears no flag.
- R5: When the first 8 bits of a frame are B0h, `fifo_pop_o` pulses high for one `clk` cycle after the 8th bit is sampled. This happens whether the frame then ends or runs on to 16 bits. No other 8-bit prefix pulses it.
- R6: `irq_n_o` is low while any of the FIFO-level, transmit-ready, external or low-supply flags is pending. The `ev_*` inputs are sampled on every `clk` edge.
- R7: Bit 7 of slot 0 enables the transmit-ready flag and bit 6 of slot 0 enables both FIFO flags. Events on a disabled source are dropped and are not reported later.
- R8: The external flag is set by a high-to-low transition of `ext_int_n_i`. Holding the pin low does not set it again after it has been cleared.
- R9: The status word is bit 15 FIFO level, 14 FIFO overflow, 13 transmit ready, 12 external, 11 low supply, and 10..0 `aux_status_i`, captured when select falls. Bit 15 appears on `spi_sdo_o` after select falls. The next bit appears after each falling serial clock edge, so the host reads bit 15-k at rising edge k+1.
- R10: A status read (first bit 0, exactly 16 bits) clears, when select rises, only the flags set in its captured word. A flag raised during the read stays pending. `irq_n_o` returns high once no flag remains pending.
- R11: During a frame whose first bit is 1, `spi_sdo_o` keeps the value it took when select fell. While select is high, `spi_sdo_o` does not change.
- R12: The FIFO-overflow flag is reported in the status word but never drives `irq_n_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn_i | input | 1 | Serial select, active low |
| spi_sck_i | input | 1 | Serial clock, idles low |
| spi_sdi_i | input | 1 | Serial data from host |
| spi_sdo_o | output | 1 | Serial status data to host |
| irq_n_o | output | 1 | Interrupt request, active low |
| ext_int_n_i | input | 1 | External interrupt pin, falling edge is the event |
| ev_tx_ready_i | input | 1 | Transmit register can take a byte |
| ev_fifo_level_i | input | 1 | Receive FIFO reached its fill level |
| ev_fifo_ovf_i | input | 1 | Receive FIFO overflowed |
| ev_low_batt_i | input | 1 | Supply below threshold |
| aux_status_i | input | 11 | Extra status bits reported in bits 10..0 |
| fifo_pop_o | output | 1 | One-cycle pulse when a FIFO read prefix arrives |
| cfg_words_o | output | 240 | Fifteen 16-bit registers, slot k at bits 16k+15..16k |

## Verification
The command decoder is driven with one write per slot, using a distinct payload each time. This includes a word starting F that reaches slot 14 only through its three-bit code, and a check after every write that the other fourteen slots are unchanged. Unmatched codes, 12-bit and 17-bit frames, and B0h prefixes of 8 and 16 bits separate a real match from a partial or wrong-length one. The interrupt side is driven one source at a time, first with the enables clear and then with them set. An event is also injected in the middle of a status read, which shows whether clearing is limited to the captured flags. A command frame is sent with a flag pending, which shows that the data-out line stays put outside status reads.

// File: rtl/xcp_pkg.sv
package xcp_pkg;

    localparam int WORD_W   = 16;
    localparam int NREG     = 15;
    localparam int FLAG_N   = 5;
    localparam int AUX_W    = WORD_W - FLAG_N;
    localparam int CNT_W    = $clog2(WORD_W + 2);
    localparam int POP_LEN  = 8;
    localparam logic [POP_LEN-1:0] POP_CODE = 8'hB0;

    localparam int CFG_SLOT       = 0;
    localparam int CFG_TXEN_BIT   = 7;
    localparam int CFG_FIFOEN_BIT = 6;

    // one command slot: code pattern (left aligned), code length, reset word
    typedef struct packed {
        logic [WORD_W-1:0] code;
        logic [3:0]        len;
        logic [WORD_W-1:0] dflt;
    } cmd_desc_t;

    // pending interrupt flags, MSB first as they appear in the status word
    typedef struct packed {
        logic flvl;
        logic fovf;
        logic txrdy;
        logic ext;
        logic lowbat;
    } irq_flags_t;

    // flags that may pull the interrupt line (overflow is report-only)
    localparam irq_flags_t IRQ_MASK = '{flvl: 1'b1, fovf: 1'b0, txrdy: 1'b1,
                                        ext: 1'b1, lowbat: 1'b1};

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  len;
    } frame_t;

    function automatic cmd_desc_t cmd_desc(input int slot);
        cmd_desc_t d;
        d.len = 4'd8;
        case (slot)
            0:  d.dflt = 16'h8008;
            1:  d.dflt = 16'h8208;
            2:  d.dflt = 16'h9080;
            3:  d.dflt = 16'h9800;
            4:  d.dflt = 16'hA680;
            5:  d.dflt = 16'hB8AA;
            6:  d.dflt = 16'hC000;
            7:  d.dflt = 16'hC22C;
            8:  d.dflt = 16'hC4F7;
            9:  d.dflt = 16'hC623;
            10: d.dflt = 16'hC80E;
            11: d.dflt = 16'hCA80;
            12: d.dflt = 16'hCC77;
            13: d.dflt = 16'hCED4;
            default: d.dflt = 16'hE196;
        endcase
        if (slot == 4)  d.len = 4'd4;
        if (slot >= 14) d.len = 4'd3;
        d.code = d.dflt & code_mask(d.len);
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] code_mask(input logic [3:0] len);
        return ~({WORD_W{1'b1}} >> len);
    endfunction

    function automatic logic code_hit(input logic [WORD_W-1:0] word,
                                      input cmd_desc_t d);
        return ((word ^ d.code) & code_mask(d.len)) == '0;
    endfunction

endpackage

// File: rtl/xcp_bit_sync.sv
module xcp_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xcp_spi_front.sv
module xcp_spi_front
    import xcp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic [WORD_W-1:0] stat_word_i,
    output logic              sel_start_o,
    output frame_t            frame_o,
    output logic              pop_o,
    output logic              sdo_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_POP  = CNT_W'(POP_LEN - 1);

    logic csn_s, sck_s, sdi_s;
    logic csn_d, sck_d;

    xcp_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn
        (.clk(clk), .rst(rst), .d_i(csn_i), .q_o(csn_s));
    xcp_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck
        (.clk(clk), .rst(rst), .d_i(sck_i), .q_o(sck_s));
    xcp_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi
        (.clk(clk), .rst(rst), .d_i(sdi_i), .q_o(sdi_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            csn_d <= csn_s;
            sck_d <= sck_s;
        end
    end

    logic sel_start, sel_end, sck_rise, sck_fall;
    assign sel_start = csn_d & ~csn_s;
    assign sel_end   = ~csn_d & csn_s;
    assign sck_rise  = ~csn_s & sck_s & ~sck_d;
    assign sck_fall  = ~csn_s & ~sck_s & sck_d;

    logic [WORD_W-1:0] shift_q, out_q, shift_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic              stat_q, sdo_q, pop_q;

    assign shift_nxt = {shift_q[WORD_W-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            out_q   <= '0;
            cnt_q   <= '0;
            stat_q  <= 1'b0;
            sdo_q   <= 1'b0;
            pop_q   <= 1'b0;
        end else begin
            pop_q <= 1'b0;
            if (sel_start) begin
                shift_q <= '0;
                cnt_q   <= '0;
                stat_q  <= 1'b0;
                out_q   <= stat_word_i;
                sdo_q   <= stat_word_i[WORD_W-1];
            end else begin
                if (sck_rise) begin
                    shift_q <= shift_nxt;
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == '0) stat_q <= ~sdi_s;
                    if (cnt_q == CNT_POP && shift_nxt[POP_LEN-1:0] == POP_CODE)
                        pop_q <= 1'b1;
                end
                if (sck_fall && stat_q && cnt_q < CNT_FULL) begin
                    out_q <= out_q << 1;
                    sdo_q <= out_q[WORD_W-2];
                end
            end
        end
    end

    assign sel_start_o   = sel_start;
    assign frame_o.valid = sel_end;
    assign frame_o.word  = shift_q;
    assign frame_o.len   = cnt_q;
    assign pop_o         = pop_q;
    assign sdo_o         = sdo_q;
endmodule

// File: rtl/xcp_regfile.sv
module xcp_regfile
    import xcp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  frame_t                   frame_i,
    output logic [NREG*WORD_W-1:0]   regs_o
);
    logic full_frame;
    assign full_frame = frame_i.valid && (frame_i.len == CNT_W'(WORD_W));

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam cmd_desc_t DESC = cmd_desc(g);
        logic [WORD_W-1:0] r_q;

        always_ff @(posedge clk) begin
            if (rst)
                r_q <= DESC.dflt;
            else if (full_frame && code_hit(frame_i.word, DESC))
                r_q <= frame_i.word;
        end

        assign regs_o[g*WORD_W +: WORD_W] = r_q;
    end
endmodule

// File: rtl/xcp_irq.sv
module xcp_irq
    import xcp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en_i,
    input  logic              fifo_en_i,
    input  logic              ev_txrdy_i,
    input  logic              ev_flvl_i,
    input  logic              ev_fovf_i,
    input  logic              ev_lowbat_i,
    input  logic              ext_n_i,
    input  logic [AUX_W-1:0]  aux_i,
    input  logic              snap_i,
    input  logic              clear_i,
    output logic [WORD_W-1:0] stat_word_o,
    output logic              irq_n_o
);
    logic ext_s, ext_d;

    xcp_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ext
        (.clk(clk), .rst(rst), .d_i(ext_n_i), .q_o(ext_s));

    irq_flags_t raw, pend_q, snap_q, kept, pend_nxt;

    always_comb begin
        raw.flvl   = ev_flvl_i & fifo_en_i;
        raw.fovf   = ev_fovf_i & fifo_en_i;
        raw.txrdy  = ev_txrdy_i & tx_en_i;
        raw.ext    = ext_d & ~ext_s;
        raw.lowbat = ev_lowbat_i;
        kept       = clear_i ? irq_flags_t'(pend_q & ~snap_q) : pend_q;
        pend_nxt   = irq_flags_t'(kept | raw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_d  <= 1'b1;
            pend_q <= '0;
            snap_q <= '0;
        end else begin
            ext_d  <= ext_s;
            pend_q <= pend_nxt;
            if (snap_i) snap_q <= pend_q;
        end
    end

    assign stat_word_o = {pend_q, aux_i};
    assign irq_n_o     = ~|(pend_q & IRQ_MASK);
endmodule

// File: rtl/xcvr_cmd_port.sv
module xcvr_cmd_port
    import xcp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   spi_csn_i,
    input  logic                   spi_sck_i,
    input  logic                   spi_sdi_i,
    output logic                   spi_sdo_o,
    output logic                   irq_n_o,
    input  logic                   ext_int_n_i,
    input  logic                   ev_tx_ready_i,
    input  logic                   ev_fifo_level_i,
    input  logic                   ev_fifo_ovf_i,
    input  logic                   ev_low_batt_i,
    input  logic [AUX_W-1:0]       aux_status_i,
    output logic                   fifo_pop_o,
    output logic [NREG*WORD_W-1:0] cfg_words_o
);
    frame_t            frame;
    logic              sel_start;
    logic              stat_done;
    logic [WORD_W-1:0] stat_word;
    logic [WORD_W-1:0] cfg_slot;

    xcp_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk         (clk),
        .rst         (rst),
        .csn_i       (spi_csn_i),
        .sck_i       (spi_sck_i),
        .sdi_i       (spi_sdi_i),
        .stat_word_i (stat_word),
        .sel_start_o (sel_start),
        .frame_o     (frame),
        .pop_o       (fifo_pop_o),
        .sdo_o       (spi_sdo_o)
    );

    xcp_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame),
        .regs_o  (cfg_words_o)
    );

    assign cfg_slot  = cfg_words_o[CFG_SLOT*WORD_W +: WORD_W];
    assign stat_done = frame.valid && (frame.len == CNT_W'(WORD_W))
                       && !frame.word[WORD_W-1];

    xcp_irq #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .tx_en_i     (cfg_slot[CFG_TXEN_BIT]),
        .fifo_en_i   (cfg_slot[CFG_FIFOEN_BIT]),
        .ev_txrdy_i  (ev_tx_ready_i),
        .ev_flvl_i   (ev_fifo_level_i),
        .ev_fovf_i   (ev_fifo_ovf_i),
        .ev_lowbat_i (ev_low_batt_i),
        .ext_n_i     (ext_int_n_i),
        .aux_i       (aux_status_i),
        .snap_i      (sel_start),
        .clear_i     (stat_done),
        .stat_word_o (stat_word),
        .irq_n_o     (irq_n_o)
    );
endmodule

// File: rtl/xcvr_cmd_port_chk.sv
module xcvr_cmd_port_chk
    import xcp_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   spi_csn_i,
    input logic                   spi_sdo_o,
    input logic                   irq_n_o,
    input logic                   ev_low_batt_i,
    input logic                   fifo_pop_o,
    input logic [NREG*WORD_W-1:0] cfg_words_o
);
    // R1: interrupt line idle right after reset is released
    a_r1_irq_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> irq_n_o);

    // R6: low-supply event always pulls the interrupt line on the next cycle
    a_r6_lowbat_irq: assert property (@(posedge clk) disable iff (rst)
        ev_low_batt_i |=> !irq_n_o);

    // R5: pop is a single-cycle pulse
    a_r5_pop_single: assert property (@(posedge clk) disable iff (rst)
        fifo_pop_o |=> !fifo_pop_o);

    // R2: registers hold while select has been low for a while
    a_r2_regs_hold_in_frame: assert property (@(posedge clk) disable iff (rst)
        (!spi_csn_i && !$past(spi_csn_i) && !$past(spi_csn_i, 2)
         && !$past(spi_csn_i, 3) && !$past(spi_csn_i, 4))
        |-> $stable(cfg_words_o));

    // R11: data-out quiet while select has been high for a while
    a_r11_sdo_quiet: assert property (@(posedge clk) disable iff (rst)
        (spi_csn_i && $past(spi_csn_i) && $past(spi_csn_i, 2)
         && $past(spi_csn_i, 3) && $past(spi_csn_i, 4))
        |-> $stable(spi_sdo_o));
endmodule

bind xcvr_cmd_port xcvr_cmd_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .spi_csn_i     (spi_csn_i),
    .spi_sdo_o     (spi_sdo_o),
    .irq_n_o       (irq_n_o),
    .ev_low_batt_i (ev_low_batt_i),
    .fifo_pop_o    (fifo_pop_o),
    .cfg_words_o   (cfg_words_o)
);

// File: tb/sim_xcvr_cmd_port.sv
module sim_xcvr_cmd_port;
    localparam int HALF = 6;
    localparam logic [10:0] AUX = 11'h5A3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic csn = 1'b1, sck = 1'b0, sdi = 1'b0, ext_n = 1'b1;
    logic ev_tx = 1'b0, ev_flvl = 1'b0, ev_fovf = 1'b0, ev_lb = 1'b0;
    logic sdo, irq_n, pop;
    logic [239:0] cfg;

    xcvr_cmd_port u0 (
        .clk(clk), .rst(rst),
        .spi_csn_i(csn), .spi_sck_i(sck), .spi_sdi_i(sdi), .spi_sdo_o(sdo),
        .irq_n_o(irq_n), .ext_int_n_i(ext_n),
        .ev_tx_ready_i(ev_tx), .ev_fifo_level_i(ev_flvl),
        .ev_fifo_ovf_i(ev_fovf), .ev_low_batt_i(ev_lb),
        .aux_status_i(AUX), .fifo_pop_o(pop), .cfg_words_o(cfg)
    );

    int checks = 0, fails = 0, pops = 0;
    bit finished = 0;

    logic [15:0] dflt [15] = '{16'h8008, 16'h8208, 16'h9080, 16'h9800, 16'hA680,
                               16'hB8AA, 16'hC000, 16'hC22C, 16'hC4F7, 16'hC623,
                               16'hC80E, 16'hCA80, 16'hCC77, 16'hCED4, 16'hE196};
    logic [15:0] wr   [15] = '{16'h80C8, 16'h8255, 16'h90F2, 16'h9871, 16'hA3C1,
                               16'hB855, 16'hC0E4, 16'hC2AB, 16'hC4B3, 16'hC611,
                               16'hC801, 16'hCA83, 16'hCC17, 16'hCE2D, 16'hF321};
    logic [15:0] cur  [15];

    always @(posedge clk) if (!rst && pop) pops++;

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        int bad = -1;
        checks++;
        for (int k = 0; k < 15; k++)
            if (bad < 0 && cfg[k*16 +: 16] !== cur[k]) bad = k;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s slot %0d actual=%h expected=%h", req, bad,
                     cfg[bad*16 +: 16], cur[bad]);
        end
    endtask

    task automatic frame(input logic [31:0] w, input int nbits, output logic [15:0] rd);
        rd = '0;
        csn = 1'b0;
        ticks(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[nbits-1-i];
            ticks(HALF);
            if (i < 16) rd[15-i] = sdo;
            sck = 1'b1;
            ticks(HALF);
            sck = 1'b0;
        end
        ticks(HALF);
        csn = 1'b1;
        ticks(10);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: ev_tx = 1'b1;
            1: ev_flvl = 1'b1;
            2: ev_fovf = 1'b1;
            default: ev_lb = 1'b1;
        endcase
        ticks(1);
        ev_tx = 1'b0; ev_flvl = 1'b0; ev_fovf = 1'b0; ev_lb = 1'b0;
        ticks(3);
    endtask

    task automatic t_reset;
        for (int k = 0; k < 15; k++) cur[k] = dflt[k];
        chk_regs("R1 defaults");
        chk("R1 irq_n", 32'(irq_n), 32'd1);
        chk("R1 sdo", 32'(sdo), 32'd0);
    endtask

    task automatic t_gating;
        logic [15:0] rd;
        pulse(0);
        pulse(1);
        chk("R7 disabled sources no irq", 32'(irq_n), 32'd1);
        frame(32'h0000, 16, rd);
        chk("R7 R9 disabled sources not reported", 32'(rd), 32'({5'b0, AUX}));
    endtask

    task automatic t_writes;
        logic [15:0] rd;
        for (int k = 0; k < 15; k++) begin
            frame(32'(wr[k]), 16, rd);
            cur[k] = wr[k];
            chk_regs("R2 R3 write slot");
        end
    endtask

    task automatic t_unknown;
        logic [15:0] rd;
        frame(32'h0000D512, 16, rd);
        frame(32'h00008455, 16, rd);
        chk_regs("R3 unmatched codes");
    endtask

    task automatic t_lengths;
        logic [15:0] rd;
        frame(32'h00000825, 12, rd);
        chk_regs("R4 short frame");
        frame({15'b0, 16'h8277, 1'b1}, 17, rd);
        chk_regs("R4 long frame");
    endtask

    task automatic t_pop;
        logic [15:0] rd;
        int p0 = pops;
        frame(32'h000000B0, 8, rd);
        chk("R5 pop after 8-bit prefix", 32'(pops - p0), 32'd1);
        frame(32'h0000B0AA, 16, rd);
        chk("R5 pop in full frame", 32'(pops - p0), 32'd2);
        frame(32'h000000B1, 8, rd);
        chk("R5 other prefix no pop", 32'(pops - p0), 32'd2);
        chk_regs("R3 pop frames leave registers");
    endtask

    task automatic t_txready;
        logic [15:0] rd;
        pulse(0);
        chk("R6 tx ready irq", 32'(irq_n), 32'd0);
        frame(32'h0000, 16, rd);
        chk("R9 tx ready bit13", 32'(rd), 32'({5'b00100, AUX}));
        chk("R10 release after read", 32'(irq_n), 32'd1);
    endtask

    task automatic t_ext;
        logic [15:0] rd;
        ext_n = 1'b0;
        ticks(8);
        chk("R8 ext fall irq", 32'(irq_n), 32'd0);
        frame(32'h0000, 16, rd);
        chk("R9 ext bit12", 32'(rd), 32'({5'b00010, AUX}));
        chk("R8 held low no relatch", 32'(irq_n), 32'd1);
        ext_n = 1'b1;
        ticks(8);
        chk("R8 rising edge no event", 32'(irq_n), 32'd1);
    endtask

    task automatic t_lowbat_ovf;
        logic [15:0] rd;
        pulse(3);
        chk("R6 low supply irq", 32'(irq_n), 32'd0);
        frame(32'h0000, 16, rd);
        chk("R9 low supply bit11", 32'(rd), 32'({5'b00001, AUX}));
        pulse(2);
        chk("R12 overflow alone no irq", 32'(irq_n), 32'd1);
        frame(32'h0000, 16, rd);
        chk("R12 overflow reported bit14", 32'(rd), 32'({5'b01000, AUX}));
    endtask

    task automatic t_mid_read;
        logic [15:0] rd;
        fork
            frame(32'h0000, 16, rd);
            begin ticks(60); pulse(3); end
        join
        chk("R10 mid-read event not in word", 32'(rd), 32'({5'b0, AUX}));
        chk("R10 mid-read event kept", 32'(irq_n), 32'd0);
        frame(32'h0000, 16, rd);
        chk("R10 later read clears", 32'(irq_n), 32'd1);
    endtask

    task automatic t_short_status;
        logic [15:0] rd;
        pulse(0);
        frame(32'h0000, 8, rd);
        chk("R4 short status read keeps flag", 32'(irq_n), 32'd0);
        frame(32'h0000, 16, rd);
        chk("R10 full read reports", 32'(rd), 32'({5'b00100, AUX}));
        chk("R10 full read releases", 32'(irq_n), 32'd1);
    endtask

    task automatic t_sdo_quiet;
        logic [15:0] rd;
        pulse(1);
        frame(32'h000082A6, 16, rd);
        cur[1] = 16'h82A6;
        chk("R11 sdo constant in command frame", 32'(rd), 32'h0000FFFF);
        chk_regs("R2 write with flag pending");
        frame(32'h0000, 16, rd);
        chk("R9 fifo level bit15", 32'(rd), 32'({5'b10000, AUX}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        ticks(5);
        rst = 1'b0;
        ticks(5);
        t_reset();
        t_gating();
        t_writes();
        t_unknown();
        t_lengths();
        t_pop();
        t_txready();
        t_ext();
        t_lowbat_ovf();
        t_mid_read();
        t_short_status();
        t_sdo_quiet();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule